// File: doc/BRIEF.md
# Indirect Memory Access Address Generator

This block lets a host reach several internal memory spaces through one data register. It holds a 9-bit indirect address, a memory-space selector and an auto-increment policy. A host write to the low address register loads the lower eight address bits. A host write to the mode register loads the top address bit, the space and the policy. Each read or write of the data register becomes a one-cycle read or write strobe on the selected space, at the address currently held.

After a data register access, the address either steps by one or stays where it is. The policy decides this, and it treats reads and writes separately. A host can therefore stream a block of memory through the data register without reloading the address. Read data from the selected space passes back to the host combinationally. Write data passes forward in the same way. The memories are outside this block.

Host register selection on `reg_sel`: 0 low address, 1 mode, 2 data, 3 unused (reads zero, writes ignored). At most one of `reg_rd`, `reg_wr` is asserted in a cycle.

Top module: `idx_addr_gen`

## Requirements
- R1: The indirect address is {mode bit 0, low address bits 7:0}. Reading the low address register (sel 0) returns address bits 7:0. Bit 0 of a mode register read (sel 1) returns address bit 8.
- R2: With policy bits (mode bits 7:6) at 00, data register accesses never change the address.
- R3: With policy 01, the address steps by one after a data register read, and a data register write leaves it unchanged.
- R4: With policy 10, the address steps by one after a data register write, and a data register read leaves it unchanged.
- R5: With policy 11, the address steps by one after a data register read and also after a data register write.
- R6: A step carries from bit 7 into bit 8, and 0x1FF steps to 0x000. Both registers read back the stepped address.
- R7: A data register access presents the pre-step address on `mem_addr` during the access cycle. The new address appears from the next cycle on.
- R8: Mode bits 5:4 select the space: 0 control, 1 data memory, 2 connection low byte, 3 connection high byte. A data register read or write raises only `mem_rd_stb[space]` or `mem_wr_stb[space]`, for exactly the access cycle. The value is also driven on `mem_space`. With no data access, no strobe is raised.
- R9: Mode bits 3:1 always read as zero, and values written to them have no effect.
- R10: A data register read returns `mem_rdata`. A data register write drives `reg_wdata` on `mem_wdata`.
- R11: After reset, the address, the space and the policy are all zero and no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Host register select |
| reg_rd | input | 1 | Host read of selected register |
| reg_wr | input | 1 | Host write of selected register |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data |
| mem_addr | output | 9 | Current indirect address |
| mem_space | output | 2 | Selected memory space |
| mem_rd_stb | output | 4 | Per-space read strobe |
| mem_wr_stb | output | 4 | Per-space write strobe |
| mem_wdata | output | 8 | Write data to the memories |
| mem_rdata | input | 8 | Read data from the selected space |

## Verification
The bench builds the block with its default parameters: a 9-bit address, an 8-bit low register and four spaces. With these values the 0x0FF carry and the 0x1FF wrap can be reached in a single access once the address is loaded. A stand-in byte memory for each of the four spaces lets written data come back through the data register. A misrouted strobe or a wrong address therefore shows up as a data mismatch as well as a strobe mismatch.

// File: rtl/idx_pkg.sv
package idx_pkg;

  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    INC_NONE   = 2'b00,
    INC_ON_RD  = 2'b01,
    INC_ON_WR  = 2'b10,
    INC_ON_ANY = 2'b11
  } inc_mode_e;

  typedef enum logic [1:0] {
    SEL_LOW  = 2'b00,
    SEL_MODE = 2'b01,
    SEL_DATA = 2'b10,
    SEL_NONE = 2'b11
  } reg_sel_e;

  // Policy bit 0 enables stepping on reads, bit 1 on writes.
  function automatic logic step_wanted(inc_mode_e m, logic rd, logic wr);
    return (rd && m[0]) || (wr && m[1]);
  endfunction

endpackage

// File: rtl/idx_addr_regs.sv
module idx_addr_regs
  import idx_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int LOW_W   = 8,
  parameter int SPACE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               low_we,
  input  logic               mode_we,
  input  logic [REG_W-1:0]   wdata,
  input  logic               data_rd,
  input  logic               data_wr,
  output logic [ADDR_W-1:0]  addr,
  output logic [SPACE_W-1:0] space,
  output inc_mode_e          inc_mode
);

  localparam int HIGH_W    = ADDR_W - LOW_W;
  localparam int SPACE_LSB = 4;
  localparam int MODE_LSB  = 6;

  logic [ADDR_W-1:0]  addr_q;
  logic [SPACE_W-1:0] space_q;
  inc_mode_e          mode_q;
  logic               step_ev;
  logic               addr_at_top;

  function automatic logic [ADDR_W-1:0] step_addr(logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  assign step_ev     = step_wanted(mode_q, data_rd, data_wr);
  assign addr_at_top = (addr_q == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      space_q <= '0;
      mode_q  <= INC_NONE;
    end else if (low_we) begin
      addr_q[LOW_W-1:0] <= wdata[LOW_W-1:0];
    end else if (mode_we) begin
      addr_q[ADDR_W-1:LOW_W] <= wdata[HIGH_W-1:0];
      space_q                <= wdata[SPACE_LSB +: SPACE_W];
      mode_q                 <= inc_mode_e'(wdata[MODE_LSB +: 2]);
    end else if (step_ev) begin
      addr_q <= step_addr(addr_q);
    end
  end

  assign addr     = addr_q;
  assign space    = space_q;
  assign inc_mode = mode_q;

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && addr_at_top) |=> (addr_q == '0)); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!low_we && !mode_we && !data_rd && !data_wr) |=> $stable(addr_q)); // R2
  AST_NONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == INC_NONE && !low_we && !mode_we) |=> $stable(addr_q)); // R2
  AST_RD_ONLY_NO_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == INC_ON_RD && data_wr) |=> $stable(addr_q)); // R3
  AST_WR_ONLY_NO_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == INC_ON_WR && data_rd) |=> $stable(addr_q)); // R4

endmodule

// File: rtl/idx_strobe_dec.sv
module idx_strobe_dec #(
  parameter int NUM_SPACES = 4,
  parameter int SPACE_W    = $clog2(NUM_SPACES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SPACE_W-1:0]    space,
  input  logic                  data_rd,
  input  logic                  data_wr,
  output logic [NUM_SPACES-1:0] rd_stb,
  output logic [NUM_SPACES-1:0] wr_stb
);

  for (genvar s = 0; s < NUM_SPACES; s++) begin : g_space
    logic hit;
    assign hit       = (space == SPACE_W'(s));
    assign rd_stb[s] = hit && data_rd;
    assign wr_stb[s] = hit && data_wr;
  end

  AST_RD_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_stb)); // R8
  AST_WR_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb)); // R8
  AST_STB_ONLY_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_rd && !data_wr) |-> ($countones({rd_stb, wr_stb}) == 0)); // R8

endmodule

// File: rtl/idx_rd_mux.sv
module idx_rd_mux
  import idx_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int LOW_W   = 8,
  parameter int SPACE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  reg_sel_e           sel,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [SPACE_W-1:0] space,
  input  inc_mode_e          inc_mode,
  input  logic [REG_W-1:0]   mem_rdata,
  output logic [REG_W-1:0]   rdata
);

  localparam int HIGH_W = ADDR_W - LOW_W;

  logic [REG_W-1:0] mode_view;

  always_comb begin
    mode_view               = '0;
    mode_view[HIGH_W-1:0]   = addr[ADDR_W-1:LOW_W];
    mode_view[4 +: SPACE_W] = space;
    mode_view[7:6]          = inc_mode;
  end

  always_comb begin
    unique case (sel)
      SEL_LOW:  rdata = REG_W'(addr[LOW_W-1:0]);
      SEL_MODE: rdata = mode_view;
      SEL_DATA: rdata = mem_rdata;
      default:  rdata = '0;
    endcase
  end

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_MODE) |-> (rdata[3:1] == 3'b000)); // R9

endmodule

// File: rtl/idx_addr_gen.sv
module idx_addr_gen
  import idx_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int LOW_W      = 8,
  parameter int NUM_SPACES = 4,
  localparam int SPACE_W   = $clog2(NUM_SPACES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            reg_sel,
  input  logic                  reg_rd,
  input  logic                  reg_wr,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [SPACE_W-1:0]    mem_space,
  output logic [NUM_SPACES-1:0] mem_rd_stb,
  output logic [NUM_SPACES-1:0] mem_wr_stb,
  output logic [REG_W-1:0]      mem_wdata,
  input  logic [REG_W-1:0]      mem_rdata
);

  reg_sel_e           sel;
  logic               low_we;
  logic               mode_we;
  logic               data_rd;
  logic               data_wr;
  logic [ADDR_W-1:0]  addr;
  logic [SPACE_W-1:0] space;
  inc_mode_e          inc_mode;

  assign sel     = reg_sel_e'(reg_sel);
  assign low_we  = reg_wr && (sel == SEL_LOW);
  assign mode_we = reg_wr && (sel == SEL_MODE);
  assign data_rd = reg_rd && (sel == SEL_DATA);
  assign data_wr = reg_wr && (sel == SEL_DATA);

  idx_addr_regs #(
    .ADDR_W (ADDR_W),
    .LOW_W  (LOW_W),
    .SPACE_W(SPACE_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .low_we  (low_we),
    .mode_we (mode_we),
    .wdata   (reg_wdata),
    .data_rd (data_rd),
    .data_wr (data_wr),
    .addr    (addr),
    .space   (space),
    .inc_mode(inc_mode)
  );

  idx_strobe_dec #(
    .NUM_SPACES(NUM_SPACES),
    .SPACE_W   (SPACE_W)
  ) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .space  (space),
    .data_rd(data_rd),
    .data_wr(data_wr),
    .rd_stb (mem_rd_stb),
    .wr_stb (mem_wr_stb)
  );

  idx_rd_mux #(
    .ADDR_W (ADDR_W),
    .LOW_W  (LOW_W),
    .SPACE_W(SPACE_W)
  ) u_mux (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .addr     (addr),
    .space    (space),
    .inc_mode (inc_mode),
    .mem_rdata(mem_rdata),
    .rdata    (reg_rdata)
  );

  assign mem_addr  = addr;
  assign mem_space = space;
  assign mem_wdata = reg_wdata;

  AST_SPACE_HOLDS_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd || data_wr) |=> $stable(mem_space)); // R8
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (mem_addr == '0 && mem_space == '0)); // R11

endmodule

// File: tb/sim_idx_addr_gen.sv
module sim_idx_addr_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_sel = 2'd3;
  logic       reg_rd = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [8:0] mem_addr;
  logic [1:0] mem_space;
  logic [3:0] mem_rd_stb;
  logic [3:0] mem_wr_stb;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  int m_addr = 0;
  int m_space = 0;
  int m_mode = 0;
  logic [7:0] ref_mem [4][512];
  logic [7:0] smem [4][512];

  always #10 clk = ~clk;

  idx_addr_gen u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .mem_addr  (mem_addr),
    .mem_space (mem_space),
    .mem_rd_stb(mem_rd_stb),
    .mem_wr_stb(mem_wr_stb),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  // stand-in memories
  assign mem_rdata = smem[mem_space][mem_addr];
  always @(posedge clk) begin
    for (int s = 0; s < 4; s++)
      if (mem_wr_stb[s]) smem[s][mem_addr] <= mem_wdata;
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=0x%0h expected=0x%0h", tag, got, exp);
    end
  endtask

  // One host access; outputs compared mid-cycle, model stepped at the edge.
  task automatic op(input int sel, input bit rd, input bit wr, input int wd, input string tag);
    int exp_rd;
    @(negedge clk);
    reg_sel = 2'(sel); reg_rd = rd; reg_wr = wr; reg_wdata = 8'(wd);
    #2;
    chk({tag, " R7 addr"}, int'(mem_addr), m_addr);
    chk({tag, " R8 space"}, int'(mem_space), m_space);
    chk({tag, " R8 rd_stb"}, int'(mem_rd_stb), (rd && sel == 2) ? (1 << m_space) : 0);
    chk({tag, " R8 wr_stb"}, int'(mem_wr_stb), (wr && sel == 2) ? (1 << m_space) : 0);
    if (wr && sel == 2) chk({tag, " R10 wdata"}, int'(mem_wdata), wd & 'hFF);
    if (rd) begin
      case (sel)
        0: exp_rd = m_addr & 'hFF;
        1: exp_rd = (m_mode << 6) | (m_space << 4) | (m_addr >> 8);
        2: exp_rd = int'(ref_mem[m_space][m_addr]);
        default: exp_rd = 0;
      endcase
      chk({tag, " R1/R9/R10 rdata"}, int'(reg_rdata), exp_rd);
    end
    @(posedge clk);
    if (wr && sel == 0) m_addr = (m_addr & 'h100) | (wd & 'hFF);
    else if (wr && sel == 1) begin
      m_addr  = (m_addr & 'hFF) | ((wd & 1) << 8);
      m_space = (wd >> 4) & 3;
      m_mode  = (wd >> 6) & 3;
    end else if (sel == 2) begin
      if (wr) ref_mem[m_space][m_addr] = 8'(wd);
      if ((rd && (m_mode & 1) != 0) || (wr && (m_mode & 2) != 0))
        m_addr = (m_addr + 1) % 512;
    end
    #1;
    reg_rd = 1'b0; reg_wr = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < 512; a++) begin
        ref_mem[s][a] = 8'((s * 37 + a * 11) & 'hFF);
        smem[s][a]    = 8'((s * 37 + a * 11) & 'hFF);
      end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11 reset state
    @(negedge clk);
    chk("R11 addr", int'(mem_addr), 0);
    chk("R11 space", int'(mem_space), 0);
    chk("R11 strobes", int'({mem_rd_stb, mem_wr_stb}), 0);
    op(1, 1, 0, 0, "R11 mode read");

    // R1 address composition
    op(0, 0, 1, 'hA5, "R1 load low");
    op(1, 0, 1, 'h01, "R1 load mode");
    op(0, 1, 0, 0, "R1 read low");
    op(1, 1, 0, 0, "R1 read mode");
    chk("R1 addr value", int'(mem_addr), 'h1A5);

    // R9 reserved bits
    op(1, 0, 1, 'h0E, "R9 write rsvd");
    op(1, 1, 0, 0, "R9 read rsvd");
    chk("R9 addr high cleared", int'(mem_addr), 'h0A5);

    // R2 no stepping
    op(1, 0, 1, 'h10, "R2 mode");
    op(2, 0, 1, 'h3C, "R2 write");
    op(2, 1, 0, 0, "R2 read");
    op(2, 1, 0, 0, "R2 read again");
    chk("R2 addr held", int'(mem_addr), 'h0A5);

    // R3 step after read only
    op(1, 0, 1, 'h40, "R3 mode");
    op(2, 0, 1, 'h11, "R3 write");
    chk("R3 write no step", int'(mem_addr), 'h0A5);
    op(2, 1, 0, 0, "R3 read");
    chk("R3 read steps", int'(mem_addr), 'h0A6);

    // R4 step after write only
    op(1, 0, 1, 'h90, "R4 mode");
    op(2, 1, 0, 0, "R4 read");
    chk("R4 read no step", int'(mem_addr), 'h0A6);
    op(2, 0, 1, 'h22, "R4 write");
    chk("R4 write steps", int'(mem_addr), 'h0A7);

    // R5 step on both
    op(1, 0, 1, 'hE0, "R5 mode");
    op(2, 0, 1, 'h33, "R5 write");
    op(2, 1, 0, 0, "R5 read");
    chk("R5 two steps", int'(mem_addr), 'h0A9);

    // R6 carry and wrap
    op(0, 0, 1, 'hFF, "R6 low ff");
    op(1, 0, 1, 'hC0, "R6 mode");
    op(2, 0, 1, 'h44, "R6 carry write");
    chk("R6 carry", int'(mem_addr), 'h100);
    op(1, 1, 0, 0, "R6 carry mode readback");
    op(0, 0, 1, 'hFF, "R6 low ff again");
    op(2, 1, 0, 0, "R6 wrap read");
    chk("R6 wrap", int'(mem_addr), 'h000);
    op(0, 1, 0, 0, "R6 wrap low readback");
    op(1, 1, 0, 0, "R6 wrap mode readback");

    // R8/R10 each space, write then read back
    for (int s = 0; s < 4; s++) begin
      op(0, 0, 1, 'h20 + s, "R8 low");
      op(1, 0, 1, 'h81 | (s << 4), "R8 mode");
      op(2, 0, 1, 'h5A ^ s, "R8 write");
      op(0, 0, 1, 'h20 + s, "R8 rewind");
      op(2, 1, 0, 0, "R10 read back");
    end

    // unused select
    op(3, 0, 1, 'hFF, "R9 unused write");
    op(3, 1, 0, 0, "R9 unused read");

    // mixed traffic compared against the model each access
    for (int i = 0; i < 400; i++) begin
      int sel;
      bit rd;
      sel = $urandom_range(0, 9);
      sel = (sel < 6) ? 2 : (sel < 8) ? 1 : (sel == 8) ? 0 : 3;
      rd  = $urandom_range(0, 1) == 1;
      op(sel, rd, !rd, int'($urandom_range(0, 255)), "R5 mixed");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule